// File: doc/BRIEF.md
# Hardwired Coprocessor Control-Instruction Decoder

This block watches the opcode stream that a host processor places on the bus. It picks out the two-byte coprocessor control instructions that bus-interface hardware executes directly, with no microcode involved. Bytes arrive one at a time, each marked by a strobe. Every byte goes through two stages. The first tests the upper five bits. The second combines that result with the lower three bits to find a small set of exact byte values. The matches from a first byte are held in latches until the following byte arrives, and the pair is then resolved into one of eleven instructions.

There are two kinds of result. Simple register-modifying instructions raise a one-cycle strobe. Long memory-moving instructions set an active flag that stays up until the bus state machine reports completion on a done input. When the full state save or the full state restore finishes its bus part, the block raises a one-cycle start request toward the microcode sequencer, which then handles the stack registers.

Top module: `hwctl_dec`

## Requirements
- R1: After reset, `pulse_o`, `act_o`, `mc_save_go` and `mc_restore_go` are all zero.
- R2: A first byte 0xDB followed by a second byte 0xE0, 0xE1, 0xE2 or 0xE3 gives a single-cycle high on `pulse_o[0]` (interrupt enable), `pulse_o[1]` (interrupt mask), `pulse_o[2]` (exception clear) or `pulse_o[3]` (initialise) respectively. The strobe appears in the cycle after the edge that samples the second byte.
- R3: These pairs each set one bit of `act_o`: 0xD9 0xE0 sets bit 0 (environment load), 0xD9 0xE1 sets bit 1 (control word load), 0xD9 0xE2 sets bit 2 (environment store), 0xD9 0xE3 sets bit 3 (control word store), 0xDD 0xE3 sets bit 4 (status word store), 0xDD 0xE2 sets bit 5 (full save) and 0xDD 0xE0 sets bit 6 (full restore). The bit appears in the cycle after the second byte is sampled and then holds.
- R4: A high `xfer_done` sampled at an edge clears `act_o` to zero at that edge. While `xfer_done` is high, no new active bit can be set. A done with nothing active has no visible effect.
- R5: At most one `act_o` bit is ever set. A long-instruction pair that arrives while a bit is set is dropped. Strobe instructions are still carried out.
- R6: A done that clears `act_o[5]` gives a one-cycle `mc_save_go` at the same edge. A done that clears `act_o[6]` does the same on `mc_restore_go`. Clearing any other bit raises neither signal.
- R7: A byte whose upper five bits are not 11011, arriving when no first byte is held, is discarded and leaves the decoder waiting for a first byte.
- R8: A byte with upper five bits 11011 other than 0xD9, 0xDB or 0xDD is taken as a first byte that matches no instruction. The byte after it is consumed as its second byte, so a following 0xD9 is not treated as a new first byte.
- R9: A second byte that does not complete one of the eleven pairs (for example 0xDB 0xDB or 0xDD 0xE1) produces no output and clears the held first-byte flags.
- R10: A byte presented while `byte_stb` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | Marks `byte_in` as a valid opcode byte this cycle |
| byte_in | input | 8 | Opcode byte |
| xfer_done | input | 1 | Bus state machine has finished the current long instruction |
| pulse_o | output | 4 | Single-cycle strobes for the simple register instructions |
| act_o | output | 7 | Sticky active flags for the long instructions |
| mc_save_go | output | 1 | One-cycle start request for the microcode save routine |
| mc_restore_go | output | 1 | One-cycle start request for the microcode restore routine |

## Verification
Every result is one register stage from its cause. Strobes and active flags appear in the cycle after the edge that samples the second byte. Clearing and the microcode start requests appear in the cycle after the edge that samples `xfer_done`. The bench changes inputs on the falling edge and holds a strobe for exactly one period. It reads the outputs on the next falling edge, which lies half a period after the edge that updates them. Strobes are read a second time one cycle later to confirm they lasted a single cycle. Active flags are read again after idle cycles to confirm they hold.

// File: rtl/hwctl_pkg.sv
package hwctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int HEAD_W  = 5;
    localparam int TAIL_W  = BYTE_W - HEAD_W;
    localparam int N_PULSE = 4;
    localparam int N_LONG  = 7;

    localparam logic [HEAD_W-1:0] ESC_HEAD = 5'b11011;
    localparam logic [HEAD_W-1:0] SEC_HEAD = 5'b11100;

    localparam logic [TAIL_W-1:0] TAIL_A = 3'd1;
    localparam logic [TAIL_W-1:0] TAIL_B = 3'd3;
    localparam logic [TAIL_W-1:0] TAIL_C = 3'd5;

    localparam int L_ENV_LD = 0;
    localparam int L_CW_LD  = 1;
    localparam int L_ENV_ST = 2;
    localparam int L_CW_ST  = 3;
    localparam int L_SW_ST  = 4;
    localparam int L_SAVE   = 5;
    localparam int L_REST   = 6;

    typedef struct packed {
        logic               esc;
        logic               grp_a;
        logic               grp_b;
        logic               grp_c;
        logic [N_PULSE-1:0] sec;
    } byte_hit_t;

    typedef struct packed {
        logic pend;
        logic a;
        logic b;
        logic c;
    } front_st_t;

    typedef struct packed {
        logic [N_PULSE-1:0] pulse;
        logic [N_LONG-1:0]  act;
        logic               save_go;
        logic               rest_go;
    } track_st_t;
endpackage

// File: rtl/hwctl_match.sv
module hwctl_match
    import hwctl_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_in,
    output byte_hit_t         hit
);
    logic [HEAD_W-1:0] head;
    logic [TAIL_W-1:0] tail;
    logic              head_esc;
    logic              head_sec;

    assign head = byte_in[BYTE_W-1:TAIL_W];
    assign tail = byte_in[TAIL_W-1:0];

    // upper-five-bit stage
    assign head_esc = (head == ESC_HEAD);
    assign head_sec = (head == SEC_HEAD);

    // lower-three-bit combining stage
    assign hit.esc   = head_esc;
    assign hit.grp_a = head_esc && (tail == TAIL_A);
    assign hit.grp_b = head_esc && (tail == TAIL_B);
    assign hit.grp_c = head_esc && (tail == TAIL_C);

    for (genvar i = 0; i < N_PULSE; i++) begin : g_sec
        assign hit.sec[i] = head_sec && (tail == TAIL_W'(i));
    end
endmodule

// File: rtl/hwctl_front.sv
module hwctl_front
    import hwctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic esc,
    input  logic grp_a,
    input  logic grp_b,
    input  logic grp_c,
    output logic pair_stb,
    output logic held_a,
    output logic held_b,
    output logic held_c
);
    front_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stb) begin
            if (st_q.pend) begin
                st_d = '0;
            end else if (esc) begin
                st_d.pend = 1'b1;
                st_d.a    = grp_a;
                st_d.b    = grp_b;
                st_d.c    = grp_c;
            end else begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair_stb = stb && st_q.pend;
    assign held_a   = st_q.a;
    assign held_b   = st_q.b;
    assign held_c   = st_q.c;
endmodule

// File: rtl/hwctl_track.sv
module hwctl_track
    import hwctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pair_stb,
    input  logic               held_a,
    input  logic               held_b,
    input  logic               held_c,
    input  logic [N_PULSE-1:0] sec,
    input  logic               done,
    output logic [N_PULSE-1:0] pulse_o,
    output logic [N_LONG-1:0]  act_o,
    output logic               save_go,
    output logic               rest_go
);
    track_st_t          st_d, st_q;
    logic [N_PULSE-1:0] pulse_req;
    logic [N_LONG-1:0]  long_req;

    always_comb begin
        pulse_req = '0;
        long_req  = '0;
        if (pair_stb) begin
            pulse_req          = held_b ? sec : '0;
            long_req[L_ENV_LD] = held_a && sec[0];
            long_req[L_CW_LD]  = held_a && sec[1];
            long_req[L_ENV_ST] = held_a && sec[2];
            long_req[L_CW_ST]  = held_a && sec[3];
            long_req[L_SW_ST]  = held_c && sec[3];
            long_req[L_SAVE]   = held_c && sec[2];
            long_req[L_REST]   = held_c && sec[0];
        end
    end

    always_comb begin
        st_d         = st_q;
        st_d.pulse   = pulse_req;
        st_d.save_go = done && st_q.act[L_SAVE];
        st_d.rest_go = done && st_q.act[L_REST];
        if (done) begin
            st_d.act = '0;
        end else if (st_q.act == '0) begin
            st_d.act = long_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
    assign act_o   = st_q.act;
    assign save_go = st_q.save_go;
    assign rest_go = st_q.rest_go;
endmodule

// File: rtl/hwctl_dec.sv
module hwctl_dec
    import hwctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_stb,
    input  logic [BYTE_W-1:0]  byte_in,
    input  logic               xfer_done,
    output logic [N_PULSE-1:0] pulse_o,
    output logic [N_LONG-1:0]  act_o,
    output logic               mc_save_go,
    output logic               mc_restore_go
);
    byte_hit_t hit;
    logic      pair_stb;
    logic      held_a, held_b, held_c;

    hwctl_match u_match (
        .byte_in (byte_in),
        .hit     (hit)
    );

    hwctl_front u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (byte_stb),
        .esc      (hit.esc),
        .grp_a    (hit.grp_a),
        .grp_b    (hit.grp_b),
        .grp_c    (hit.grp_c),
        .pair_stb (pair_stb),
        .held_a   (held_a),
        .held_b   (held_b),
        .held_c   (held_c)
    );

    hwctl_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .pair_stb (pair_stb),
        .held_a   (held_a),
        .held_b   (held_b),
        .held_c   (held_c),
        .sec      (hit.sec),
        .done     (xfer_done),
        .pulse_o  (pulse_o),
        .act_o    (act_o),
        .save_go  (mc_save_go),
        .rest_go  (mc_restore_go)
    );
endmodule

// File: rtl/hwctl_chk.sv
module hwctl_chk
    import hwctl_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               byte_stb,
    input logic               xfer_done,
    input logic [N_PULSE-1:0] pulse_o,
    input logic [N_LONG-1:0]  act_o,
    input logic               mc_save_go,
    input logic               mc_restore_go
);
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_o)); // R2

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o != '0 && !xfer_done) |=> (act_o == $past(act_o))); // R3

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (act_o == '0)); // R4

    AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_o) <= 1); // R5

    AST_SAVE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && act_o[L_SAVE]) |=> mc_save_go); // R6

    AST_GO_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_done && (act_o[L_SAVE] || act_o[L_REST])) |=> !mc_save_go && !mc_restore_go); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_stb && !xfer_done) |=> (pulse_o == '0) && $stable(act_o)); // R10
endmodule

bind hwctl_dec hwctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_stb      (byte_stb),
    .xfer_done     (xfer_done),
    .pulse_o       (pulse_o),
    .act_o         (act_o),
    .mc_save_go    (mc_save_go),
    .mc_restore_go (mc_restore_go)
);

// File: tb/sim_hwctl_dec.sv
module sim_hwctl_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       xfer_done = 1'b0;
    logic [3:0] pulse_o;
    logic [6:0] act_o;
    logic       mc_save_go, mc_restore_go;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    hwctl_dec u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_stb      (byte_stb),
        .byte_in       (byte_in),
        .xfer_done     (xfer_done),
        .pulse_o       (pulse_o),
        .act_o         (act_o),
        .mc_save_go    (mc_save_go),
        .mc_restore_go (mc_restore_go)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_stb = 1'b1;
        byte_in  = b;
        @(negedge clk);
        byte_stb = 1'b0;
        byte_in  = 8'h00;
    endtask

    task automatic finish_xfer();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pulse", {4'h0, pulse_o}, 8'h00);
        check("R1 act", {1'b0, act_o}, 8'h00);
        check("R1 go", {6'h0, mc_save_go, mc_restore_go}, 8'h00);
    endtask

    task automatic t_pulses();
        for (int i = 0; i < 4; i++) begin
            send(8'hDB);
            check("R2 no early", {4'h0, pulse_o}, 8'h00);
            send(8'hE0 + 8'(i));
            check("R2 strobe", {4'h0, pulse_o}, 8'(1 << i));
            check("R2 no act", {1'b0, act_o}, 8'h00);
            idle(1);
            check("R2 one cycle", {4'h0, pulse_o}, 8'h00);
        end
    endtask

    task automatic t_long();
        logic [7:0] first [7] = '{8'hD9, 8'hD9, 8'hD9, 8'hD9, 8'hDD, 8'hDD, 8'hDD};
        logic [7:0] second[7] = '{8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE3, 8'hE2, 8'hE0};
        for (int k = 0; k < 7; k++) begin
            send(first[k]);
            send(second[k]);
            check("R3 set", {1'b0, act_o}, 8'(1 << k));
            check("R3 no strobe", {4'h0, pulse_o}, 8'h00);
            idle(3);
            check("R3 hold", {1'b0, act_o}, 8'(1 << k));
            finish_xfer();
            check("R4 clear", {1'b0, act_o}, 8'h00);
            check("R6 go", {6'h0, mc_save_go, mc_restore_go},
                  (k == 5) ? 8'h02 : (k == 6) ? 8'h01 : 8'h00);
            idle(1);
            check("R6 go one cycle", {6'h0, mc_save_go, mc_restore_go}, 8'h00);
        end
        finish_xfer();
        check("R4 idle done", {1'b0, act_o}, 8'h00);
        check("R4 idle done go", {6'h0, mc_save_go, mc_restore_go}, 8'h00);
    endtask

    task automatic t_exclusive();
        send(8'hD9);
        send(8'hE2);
        send(8'hDD);
        send(8'hE2);
        check("R5 second dropped", {1'b0, act_o}, 8'h04);
        send(8'hDB);
        send(8'hE2);
        check("R5 strobe while busy", {4'h0, pulse_o}, 8'h04);
        finish_xfer();
        check("R5 cleared", {1'b0, act_o}, 8'h00);
        check("R6 no save go", {6'h0, mc_save_go, mc_restore_go}, 8'h00);
    endtask

    task automatic t_done_blocks();
        @(negedge clk);
        xfer_done = 1'b1;
        send(8'hDD);
        send(8'hE0);
        check("R4 set blocked by done", {1'b0, act_o}, 8'h00);
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic t_nonesc();
        send(8'hE0);
        check("R7 lone byte", {4'h0, pulse_o}, 8'h00);
        send(8'hE1);
        check("R7 lone byte 2", {3'h0, pulse_o, 1'b0}, 8'h00);
        send(8'hDB);
        send(8'hE0);
        check("R7 recovers", {4'h0, pulse_o}, 8'h01);
    endtask

    task automatic t_foreign();
        send(8'hD8);
        send(8'hD9);
        send(8'hE0);
        check("R8 D9 consumed", {1'b0, act_o}, 8'h00);
        send(8'hDB);
        send(8'hE1);
        check("R8 later pair", {4'h0, pulse_o}, 8'h02);
    endtask

    task automatic t_bad_second();
        send(8'hDB);
        send(8'hDB);
        check("R9 no strobe", {4'h0, pulse_o}, 8'h00);
        send(8'hE2);
        check("R9 latch cleared", {4'h0, pulse_o}, 8'h00);
        send(8'hDD);
        send(8'hE1);
        check("R9 unused pair", {1'b0, act_o}, 8'h00);
    endtask

    task automatic t_no_stb();
        @(negedge clk);
        byte_in = 8'hDB;
        @(negedge clk);
        byte_in = 8'h00;
        send(8'hE3);
        check("R10 ignored", {4'h0, pulse_o}, 8'h00);
        check("R10 ignored act", {1'b0, act_o}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulses();
        t_long();
        t_exclusive();
        t_done_blocks();
        t_nonesc();
        t_foreign();
        t_bad_second();
        t_no_stb();
        idle(2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule